// File: doc/BRIEF.md
# Memory Controller Configuration Block with Row-Probe Alias Window

This block holds the configuration and status registers of an SDRAM controller. It also produces an address alias that boot firmware relies on when it sizes memory. Software programs the controller's geometry (row bits, bank bits and page size) through a 32-bit register port with three register banks: common, controller and PHY. The command sequencer and the physical interface are not part of this block.

Firmware usually sizes memory by programming the widest row setting, writing a pattern at a row-boundary address and reading it back from the start of RAM. On a device smaller than the programmed row width, the real part wraps that boundary address back to the start. This block reproduces the wrap with a 4 KiB mirror window. A write to the common control word places the window at RAM base plus 2^(true row bits + bank bits) × page size, or removes it when the programmed row bits match the installed size. The installed size, `RAM_MIB`, is a power of two from 256 to 2048 MiB, and the true row bit count is log2(`RAM_MIB`) + 3. The memory path drives `probe_addr`. While the window is present, a hit returns the redirected address into the first 4 KiB of RAM.

The window is held by a two-state machine. WIN_OFF is the reset state, with the window parked at RAM base + 1 MiB and disabled. In WIN_ON the window is enabled at a programmed base. The transitions are all taken on a control-word write:
- ARM (WIN_OFF to WIN_ON) when the geometry mismatches the installed size.
- MOVE (WIN_ON to WIN_ON, with a new base) on a mismatch.
- DROP (WIN_ON to WIN_OFF) on a match.
- IDLE, where the state holds, on any other cycle, or on a matching write in WIN_OFF.

Top module: `dram_cfg_alias`

## Requirements
- R1: After reset every register of all three banks reads zero, and the window is disabled: no probe address hits, including the parked placement RAM base + 1 MiB.
- R2: The common control word (bank code 0, byte offset 0x00) is decoded as follows. Row bits are bits [7:4] + 1. Bank bits are bit [2] + 2. The page size is 2^(bits [11:8] + 3) bytes.
- R3: A control-word write whose row bits satisfy `RAM_MIB` == 2^(row bits − 3) disables the window from the next clock edge. For `RAM_MIB` = 256 this means bits [7:4] = 10.
- R4: Any other control-word write enables the window from the next clock edge, with its base at RAM base + 2^(log2(`RAM_MIB`) + 3 + bank bits) × page size, truncated to `ADDR_W` bits.
- R5: While the window is enabled, a probe address in [base, base + 4096) asserts `remap_hit`, and `remap_addr` is then RAM base + (probe − base). Every other probe address gives `remap_hit` = 0 and `remap_addr` = `probe_addr`.
- R6: Any write to the controller bank (code 1) at offset 0x00 sets bit 0 of the controller registers at offsets 0x10 and 0x18 and stores the written word at 0x00.
- R7: An aligned write to an implemented word of any bank is read back in full. Read data appears on `rsp_rdata` in the cycle after the read request and is zero in cycles with no read.
- R8: Word indices at or above the bank's register count read zero, and writes to them change no register.
- R9: Accesses with `req_addr[1:0]` ≠ 0, or with bank code 3, are ignored: writes change nothing, including the window, and reads return zero.
- R10: The window state and base change only on a control-word write. Writes to other words, misaligned writes and bank-3 writes leave it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank: 0 common, 1 controller, 2 PHY, 3 unused |
| req_addr | input | 12 | Byte offset inside the 4 KiB bank |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| probe_addr | input | ADDR_W | Byte address from the memory path |
| remap_hit | output | 1 | Probe lies inside the enabled window |
| remap_addr | output | ADDR_W | Redirected address on a hit, otherwise the probe address |

## Verification
A wrong window state shows at the ports in the very next cycle. A probe at the computed base either hits when it should not or misses when it should. A misplaced base or a wrong window size is caught by the probes one byte below the base, at the base, at the last covered byte and one byte past the end. A stuck status flag or a wrong register index shows on the read of that word one cycle after the request. The bench therefore sweeps all 512 geometry settings and probes every edge of the window after each one.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;

    typedef enum logic [1:0] {
        BANK_COM = 2'd0,
        BANK_CTL = 2'd1,
        BANK_PHY = 2'd2,
        BANK_NONE = 2'd3
    } bank_e;

    typedef enum logic {
        WIN_OFF = 1'b0,
        WIN_ON  = 1'b1
    } win_state_e;

    localparam int WORD_IDX_W = 10;   // 4 KiB bank / 4-byte words
    localparam int WIN_BYTES  = 4096;

    // controller bank word indices
    localparam int CTL_INIT_IDX   = 0;  // byte 0x00
    localparam int CTL_PSTAT_IDX  = 4;  // byte 0x10
    localparam int CTL_ACTIVE_IDX = 6;  // byte 0x18

endpackage

// File: rtl/dcfg_regfile.sv
module dcfg_regfile #(
    parameter int NREG    = 16,
    parameter int IDX_W   = 10,
    parameter bit HAS_SET = 1'b0,
    parameter int SET_A   = 0,
    parameter int SET_B   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic             set_en,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [31:0] words [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_word
        localparam bit IS_FLAG = HAS_SET && ((i == SET_A) || (i == SET_B));
        logic [31:0] q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (widx == IDX_W'(i))) begin
                q <= wdata;
            end else if (IS_FLAG && set_en) begin
                q[0] <= 1'b1;
            end
        end

        assign words[i] = q;
    end

    always_comb begin
        rdata = '0;
        if (ridx < IDX_W'(NREG)) begin
            rdata = words[ridx[SEL_W-1:0]];
        end
    end

endmodule

// File: rtl/dcfg_geom_decode.sv
module dcfg_geom_decode #(
    parameter int              RAM_MIB  = 256,
    parameter int              ADDR_W   = 40,
    parameter logic [ADDR_W-1:0] RAM_BASE = '0
) (
    input  logic [3:0]        row_field,
    input  logic              bank_field,
    input  logic [3:0]        page_field,
    output logic              geo_match,
    output logic [ADDR_W-1:0] new_base
);
    localparam int TRUE_ROWS = $clog2(RAM_MIB) + 3;

    logic [4:0]  row_bits;
    logic [1:0]  bank_bits;
    logic [4:0]  page_exp;
    logic [5:0]  shift_amt;
    logic [63:0] implied_mib;
    logic [63:0] span;
    logic [63:0] sum;

    always_comb begin
        row_bits  = {1'b0, row_field} + 5'd1;
        bank_bits = {1'b0, bank_field} + 2'd2;
        page_exp  = {1'b0, page_field} + 5'd3;

        implied_mib = '0;
        if (row_bits >= 5'd3) begin
            implied_mib = 64'd1 << (row_bits - 5'd3);
        end
        geo_match = (implied_mib == 64'(RAM_MIB));

        shift_amt = 6'(TRUE_ROWS) + {4'd0, bank_bits} + {1'b0, page_exp};
        span      = 64'd1 << shift_amt;
        sum       = 64'(RAM_BASE) + span;
        new_base  = sum[ADDR_W-1:0];
    end

endmodule

// File: rtl/dcfg_window_fsm.sv
module dcfg_window_fsm
    import dcfg_pkg::*;
#(
    parameter int              ADDR_W   = 40,
    parameter logic [ADDR_W-1:0] RAM_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              geo_match,
    input  logic [ADDR_W-1:0] new_base,
    output logic              win_on,
    output logic [ADDR_W-1:0] win_base
);
    localparam logic [ADDR_W-1:0] PARK_BASE = RAM_BASE + ADDR_W'(1 << 20);

    win_state_e        st_q, st_d;
    logic [ADDR_W-1:0] base_q, base_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WIN_OFF;
            base_q <= PARK_BASE;
        end else begin
            st_q   <= st_d;
            base_q <= base_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        base_d = base_q;
        unique case (st_q)
            WIN_OFF: begin
                if (cfg_we && !geo_match) begin   // ARM
                    st_d   = WIN_ON;
                    base_d = new_base;
                end
            end
            WIN_ON: begin
                if (cfg_we) begin
                    if (geo_match) begin          // DROP
                        st_d = WIN_OFF;
                    end else begin                // MOVE
                        base_d = new_base;
                    end
                end
            end
        endcase
    end

    always_comb begin
        win_on   = (st_q == WIN_ON);
        win_base = base_q;
    end

endmodule

// File: rtl/dcfg_remap.sv
module dcfg_remap
    import dcfg_pkg::*;
#(
    parameter int              ADDR_W   = 40,
    parameter logic [ADDR_W-1:0] RAM_BASE = '0
) (
    input  logic              win_on,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              remap_hit,
    output logic [ADDR_W-1:0] remap_addr
);
    logic [ADDR_W-1:0] delta;

    always_comb begin
        delta      = probe_addr - win_base;
        remap_hit  = win_on && (probe_addr >= win_base) && (delta < ADDR_W'(WIN_BYTES));
        remap_addr = remap_hit ? (RAM_BASE + delta) : probe_addr;
    end

endmodule

// File: rtl/dram_cfg_alias.sv
module dram_cfg_alias
    import dcfg_pkg::*;
#(
    parameter int              RAM_MIB  = 256,
    parameter int              ADDR_W   = 40,
    parameter logic [ADDR_W-1:0] RAM_BASE = 40'h00_4000_0000,
    parameter int              COM_REGS = 16,
    parameter int              CTL_REGS = 16,
    parameter int              PHY_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_bank,
    input  logic [11:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              remap_hit,
    output logic [ADDR_W-1:0] remap_addr
);
    bank_e                 bank;
    logic                  aligned;
    logic [WORD_IDX_W-1:0] word;
    logic                  wr_ok, rd_ok;
    logic                  com_we, ctl_we, phy_we;
    logic                  cfg_we, phy_init;
    logic [31:0]           com_rd, ctl_rd, phy_rd;
    logic                  geo_match;
    logic [ADDR_W-1:0]     new_base;
    logic                  win_on;
    logic [ADDR_W-1:0]     win_base;

    always_comb begin
        bank     = bank_e'(req_bank);
        aligned  = (req_addr[1:0] == 2'b00);
        word     = req_addr[11:2];
        wr_ok    = req_valid && req_write && aligned;
        rd_ok    = req_valid && !req_write && aligned;
        com_we   = wr_ok && (bank == BANK_COM);
        ctl_we   = wr_ok && (bank == BANK_CTL);
        phy_we   = wr_ok && (bank == BANK_PHY);
        cfg_we   = com_we && (word == '0);
        phy_init = ctl_we && (word == WORD_IDX_W'(CTL_INIT_IDX));
    end

    dcfg_regfile #(
        .NREG(COM_REGS), .IDX_W(WORD_IDX_W), .HAS_SET(1'b0), .SET_A(0), .SET_B(0)
    ) u_com (
        .clk(clk), .rst_n(rst_n), .we(com_we), .widx(word), .wdata(req_wdata),
        .set_en(1'b0), .ridx(word), .rdata(com_rd)
    );

    dcfg_regfile #(
        .NREG(CTL_REGS), .IDX_W(WORD_IDX_W), .HAS_SET(1'b1),
        .SET_A(CTL_PSTAT_IDX), .SET_B(CTL_ACTIVE_IDX)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .widx(word), .wdata(req_wdata),
        .set_en(phy_init), .ridx(word), .rdata(ctl_rd)
    );

    dcfg_regfile #(
        .NREG(PHY_REGS), .IDX_W(WORD_IDX_W), .HAS_SET(1'b0), .SET_A(0), .SET_B(0)
    ) u_phy (
        .clk(clk), .rst_n(rst_n), .we(phy_we), .widx(word), .wdata(req_wdata),
        .set_en(1'b0), .ridx(word), .rdata(phy_rd)
    );

    dcfg_geom_decode #(
        .RAM_MIB(RAM_MIB), .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE)
    ) u_geom (
        .row_field(req_wdata[7:4]), .bank_field(req_wdata[2]),
        .page_field(req_wdata[11:8]), .geo_match(geo_match), .new_base(new_base)
    );

    dcfg_window_fsm #(
        .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .geo_match(geo_match),
        .new_base(new_base), .win_on(win_on), .win_base(win_base)
    );

    dcfg_remap #(
        .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE)
    ) u_remap (
        .win_on(win_on), .win_base(win_base), .probe_addr(probe_addr),
        .remap_hit(remap_hit), .remap_addr(remap_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (rd_ok) begin
            case (bank)
                BANK_COM: rsp_rdata <= com_rd;
                BANK_CTL: rsp_rdata <= ctl_rd;
                BANK_PHY: rsp_rdata <= phy_rd;
                default:  rsp_rdata <= '0;
            endcase
        end else begin
            rsp_rdata <= '0;
        end
    end

endmodule

// File: rtl/dcfg_checker.sv
module dcfg_checker #(
    parameter int              ADDR_W   = 40,
    parameter logic [ADDR_W-1:0] RAM_BASE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_bank,
    input logic [11:0]       req_addr,
    input logic [31:0]       rsp_rdata,
    input logic [ADDR_W-1:0] probe_addr,
    input logic              remap_hit,
    input logic [ADDR_W-1:0] remap_addr,
    input logic              win_on,
    input logic              cfg_we,
    input logic              geo_match
);
    localparam logic [ADDR_W-1:0] WIN_END = RAM_BASE + ADDR_W'(4096);

    logic ctl_wr, init_wr, pstat_wr, act_wr;
    logic seen_pstat, seen_act;

    always_comb begin
        ctl_wr   = req_valid && req_write && (req_bank == 2'd1) && (req_addr[1:0] == 2'b00);
        init_wr  = ctl_wr && (req_addr == 12'h000);
        pstat_wr = ctl_wr && (req_addr == 12'h010);
        act_wr   = ctl_wr && (req_addr == 12'h018);
    end

    // independent record of whether bit 0 of 0x10 / 0x18 must now be set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_pstat <= 1'b0;
            seen_act   <= 1'b0;
        end else begin
            if (init_wr)       seen_pstat <= 1'b1;
            else if (pstat_wr) seen_pstat <= 1'b0;
            if (init_wr)       seen_act   <= 1'b1;
            else if (act_wr)   seen_act   <= 1'b0;
        end
    end

    // R3
    match_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && geo_match |=> !win_on);

    // R4
    mismatch_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !geo_match |=> win_on);

    // R5
    hit_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_hit |-> win_on);

    // R5
    hit_lands_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_hit |-> (remap_addr >= RAM_BASE) && (remap_addr < WIN_END));

    // R5
    miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !remap_hit |-> remap_addr == probe_addr);

    // R6
    pstat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_bank == 2'd1 && req_addr == 12'h010 && seen_pstat
        |=> rsp_rdata[0]);

    // R6
    active_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_bank == 2'd1 && req_addr == 12'h018 && seen_act
        |=> rsp_rdata[0]);

    // R9
    dead_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && (req_bank == 2'd3 || req_addr[1:0] != 2'b00)
        |=> rsp_rdata == 32'd0);

    // R7
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> rsp_rdata == 32'd0);

    // R10
    window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(win_on));

endmodule

bind dram_cfg_alias dcfg_checker #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE)) u_chk (.*);

// File: tb/dram_cfg_alias_test.sv
module dram_cfg_alias_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 40;
    localparam int RAM_MIB    = 256;
    localparam logic [ADDR_W-1:0] RAM_BASE = 40'h00_4000_0000;
    localparam int NREG       = 16;
    localparam int TRUE_ROWS  = $clog2(RAM_MIB) + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_bank = 2'd0;
    logic [11:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rsp_rdata;
    logic [ADDR_W-1:0] probe_addr = '0;
    logic              remap_hit;
    logic [ADDR_W-1:0] remap_addr;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cfg_alias #(
        .RAM_MIB(RAM_MIB), .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE),
        .COM_REGS(NREG), .CTL_REGS(NREG), .PHY_REGS(NREG)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .probe_addr(probe_addr),
        .remap_hit(remap_hit), .remap_addr(remap_addr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] b, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_bank = b; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] b, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_bank = b; req_addr = a;
        @(negedge clk);
        d = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] b, input logic [11:0] a,
                          input logic [31:0] exp);
        logic [31:0] d;
        rd(b, a, d);
        check(req, 64'(d), 64'(exp));
    endtask

    task automatic probe(input string req, input logic [ADDR_W-1:0] a,
                         input logic exp_hit, input logic [ADDR_W-1:0] exp_addr);
        probe_addr = a;
        #1;
        check({req, " hit"}, 64'(remap_hit), 64'(exp_hit));
        check({req, " addr"}, 64'(remap_addr), 64'(exp_addr));
    endtask

    function automatic logic [ADDR_W-1:0] calc_base(input int bb, input int pf);
        logic [63:0] v;
        v = 64'(RAM_BASE) + (64'd1 << (TRUE_ROWS + 2 + bb + pf + 3));
        return v[ADDR_W-1:0];
    endfunction

    function automatic logic [31:0] ctl_word(input int rf, input int bb, input int pf);
        return (32'(pf) << 8) | (32'(rf) << 4) | (32'(bb) << 2);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] b, keep;
        do_reset();

        // R1: every word of every bank reads zero, window parked and disabled
        for (int bk = 0; bk < 3; bk++) begin
            for (int w = 0; w < NREG; w++) begin
                rd_chk("R1 reset value", 2'(bk), 12'(w * 4), 32'd0);
            end
        end
        probe("R1 parked window", RAM_BASE + 40'h10_0000, 1'b0, RAM_BASE + 40'h10_0000);
        probe("R1 ram base", RAM_BASE, 1'b0, RAM_BASE);

        // R6: PHY-init write sets both flags and stores the word
        wr(2'd1, 12'h000, 32'hA5A5_0000);
        rd_chk("R6 init word stored", 2'd1, 12'h000, 32'hA5A5_0000);
        rd_chk("R6 phy status flag", 2'd1, 12'h010, 32'd1);
        rd_chk("R6 active flag", 2'd1, 12'h018, 32'd1);
        wr(2'd1, 12'h010, 32'h0000_0000);
        rd_chk("R7 status overwritten", 2'd1, 12'h010, 32'd0);
        wr(2'd1, 12'h000, 32'h0000_0003);
        rd_chk("R6 flag set again", 2'd1, 12'h010, 32'd1);

        // R7: full-word readback in every bank
        for (int bk = 0; bk < 3; bk++) begin
            for (int w = 1; w < NREG; w++) begin
                if (!(bk == 1 && (w == 4 || w == 6))) begin
                    wr(2'(bk), 12'(w * 4), 32'h1234_0000 ^ 32'(bk << 12) ^ 32'(w * 32'h0101_0101));
                end
            end
            for (int w = 1; w < NREG; w++) begin
                if (!(bk == 1 && (w == 4 || w == 6))) begin
                    rd_chk("R7 readback", 2'(bk), 12'(w * 4),
                           32'h1234_0000 ^ 32'(bk << 12) ^ 32'(w * 32'h0101_0101));
                end
            end
        end

        // R8: beyond implemented words
        wr(2'd2, 12'h000, 32'h0BAD_F00D);
        wr(2'd2, 12'(NREG * 4), 32'hDEAD_BEEF);
        rd_chk("R8 beyond reads zero", 2'd2, 12'(NREG * 4), 32'd0);
        rd_chk("R8 no alias onto word 0", 2'd2, 12'h000, 32'h0BAD_F00D);
        rd_chk("R8 far word reads zero", 2'd2, 12'hFFC, 32'd0);

        // R9: misaligned and bank 3
        wr(2'd2, 12'h001, 32'h5555_5555);
        rd_chk("R9 misaligned write ignored", 2'd2, 12'h000, 32'h0BAD_F00D);
        rd_chk("R9 misaligned read zero", 2'd2, 12'h002, 32'd0);
        wr(2'd3, 12'h000, 32'h7777_7777);
        rd_chk("R9 bank3 read zero", 2'd3, 12'h000, 32'd0);
        rd_chk("R9 bank3 no spill", 2'd0, 12'h000, 32'd0);

        // R2 R3 R4 R5: exhaustive geometry sweep
        for (int rf = 0; rf < 16; rf++) begin
            for (int bb = 0; bb < 2; bb++) begin
                for (int pf = 0; pf < 16; pf++) begin
                    wr(2'd0, 12'h000, ctl_word(rf, bb, pf));
                    rd_chk("R7 control readback", 2'd0, 12'h000, ctl_word(rf, bb, pf));
                    b = calc_base(bb, pf);
                    if (rf + 1 == TRUE_ROWS) begin
                        probe("R3 window removed", b, 1'b0, b);
                    end else begin
                        probe("R4 base", b, 1'b1, RAM_BASE);
                        probe("R5 last byte", b + 40'd4095, 1'b1, RAM_BASE + 40'd4095);
                        probe("R5 below base", b - 40'd1, 1'b0, b - 40'd1);
                        probe("R2 past end", b + 40'd4096, 1'b0, b + 40'd4096);
                    end
                end
            end
        end

        // R10: only control-word writes move the window
        wr(2'd0, 12'h000, ctl_word(15, 1, 2));
        keep = calc_base(1, 2);
        probe("R4 armed", keep + 40'd100, 1'b1, RAM_BASE + 40'd100);
        wr(2'd0, 12'h001, ctl_word(TRUE_ROWS - 1, 0, 0));
        probe("R10 misaligned ctl write", keep, 1'b1, RAM_BASE);
        wr(2'd0, 12'h004, ctl_word(TRUE_ROWS - 1, 0, 0));
        probe("R10 other common word", keep, 1'b1, RAM_BASE);
        wr(2'd3, 12'h000, ctl_word(TRUE_ROWS - 1, 0, 0));
        probe("R10 bank3 write", keep, 1'b1, RAM_BASE);
        wr(2'd1, 12'h000, ctl_word(TRUE_ROWS - 1, 0, 0));
        probe("R10 controller write", keep, 1'b1, RAM_BASE);
        wr(2'd0, 12'h000, ctl_word(TRUE_ROWS - 1, 1, 2));
        probe("R3 drop", keep, 1'b0, keep);

        // R1: reset mid-run clears registers and window
        wr(2'd0, 12'h000, ctl_word(15, 0, 0));
        keep = calc_base(0, 0);
        probe("R4 re-armed", keep, 1'b1, RAM_BASE);
        do_reset();
        probe("R1 window off after reset", keep, 1'b0, keep);
        rd_chk("R1 control cleared", 2'd0, 12'h000, 32'd0);
        rd_chk("R1 flag cleared", 2'd1, 12'h010, 32'd0);
        rd_chk("R1 phy cleared", 2'd2, 12'h000, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule